// File: doc/BRIEF.md
# Runtime-Configurable Binary Extension Field Arithmetic Unit

This unit computes multiply, add, inverse and modulo-reduce in a binary extension field GF(2^m). The field size m and the reduction polynomial are both supplied with each request, so one engine serves any field from GF(2) up to GF(2^W) without being rebuilt. The reduction polynomial is given by its low coefficients only. The leading x^m term is implied. For example, the field built on x^8+x^4+x^3+x+1 is selected by degree 8 and modulus 0x1B.

A request is presented on `start` together with the operation code, the degree, the operands and the modulus. It is accepted on any rising edge where the unit is not busy. Add finishes at once. Multiply and reduce run a bit-serial shift-and-reduce loop. Inverse steps an extended-Euclid loop over polynomials, one subtract-and-shift per clock. Each accepted request ends with a one-cycle `done` pulse. The result is then held on `result` until the next `done`.

Top module: `gf_arith_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `busy` and `done` are 0 and `result` is 0.
- R2: Operation code 2'b00 returns the product of the low m bits of `opa` and `opb`, reduced modulo x^m + `modpoly`. `done` rises m+1 edges after the accepting edge. With m=3 and modulus 3, 7 times 5 gives 6. With m=8 and modulus 0x1B, 0x80 times 0x83 gives 0x01.
- R3: Operation code 2'b01 returns the XOR of the low m bits of `opa` and `opb`. `done` is high in the cycle right after the accepting edge, and `busy` stays low.
- R4: Operation code 2'b10 returns the x that satisfies `opa`·x = 1 in the field. It returns 0 when `opa` is 0 or when no inverse exists because the modulus is reducible. `done` rises at most 2m+2 edges after the accepting edge. With m=8 and modulus 0x1B, the inverse of 0x53 is 0xCA.
- R5: Operation code 2'b11 reduces the full 2W-bit `opa` modulo x^m + `modpoly` to a value below 2^m. `done` rises 2W+1 edges after the accepting edge.
- R6: A `deg` value of 0 or greater than W is treated as m = W.
- R7: Bits of `opa` (except in reduce), `opb` and `modpoly` at position m and above have no effect, and `result` never has a bit set at position m or above.
- R8: A `start` that is seen while `busy` is high is ignored. It changes neither the result nor the number of `done` pulses.
- R9: Each accepted request gives exactly one single-cycle `done` pulse, which is never high together with `busy`. `result` changes only in a cycle where `done` is high.
- R10: After a multiply, inverse or reduce request is accepted, `busy` is high from the next cycle until the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when not busy |
| op | input | 2 | 00 multiply, 01 add, 10 inverse, 11 reduce |
| deg | input | $clog2(W+1) | Field degree m (1..W) |
| opa | input | 2W | First operand; reduce uses all bits |
| opb | input | W | Second operand |
| modpoly | input | W | Reduction polynomial coefficients below x^m |
| busy | output | 1 | A multi-cycle operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Result, held between completions |

## Verification
Latency is counted from the rising edge that accepts `start`. Add shows `done` in the cycle right after that edge. Multiply shows it m+1 edges later, reduce 2W+1 edges later, and inverse after a data-dependent count bounded by 2m+2. The bench drives requests on falling edges and counts whole clock periods at falling edges until `done` appears. It then compares that count exactly for add, multiply and reduce, and against the bound for inverse, before it reads `result`. Busy is sampled at the first falling edge after acceptance. The quiet behaviour after completion is sampled over the following few falling edges.

// File: rtl/gf_pkg.sv
package gf_pkg;

    localparam int GF_MAXW = 64;
    localparam int GF_DEGW = 7;

    typedef logic [GF_MAXW:0]    gf_wide_t;
    typedef logic [GF_DEGW-1:0]  gf_deg_t;

    typedef enum logic [1:0] {
        GF_OP_MUL = 2'b00,
        GF_OP_ADD = 2'b01,
        GF_OP_INV = 2'b10,
        GF_OP_RED = 2'b11
    } gf_op_e;

    typedef enum logic [1:0] {
        GF_ST_IDLE   = 2'd0,
        GF_ST_SHIFT  = 2'd1,
        GF_ST_EUCLID = 2'd2
    } gf_state_e;

    // Working state of the polynomial extended-Euclid loop.
    typedef struct packed {
        gf_wide_t u;
        gf_wide_t v;
        gf_wide_t g1;
        gf_wide_t g2;
    } gf_euclid_t;

    // Ones in every position below m.
    function automatic gf_wide_t gf_mask(input gf_deg_t m);
        gf_wide_t r;
        r = '0;
        for (int i = 0; i <= GF_MAXW; i++) begin
            r[i] = (i < int'(m));
        end
        return r;
    endfunction

    // Index of the highest set bit (0 for a zero vector).
    function automatic gf_deg_t gf_top_bit(input gf_wide_t v);
        gf_deg_t d;
        d = '0;
        for (int i = 0; i <= GF_MAXW; i++) begin
            if (v[i]) d = gf_deg_t'(i);
        end
        return d;
    endfunction

    // Multiply v (below degree m) by x, add bit b, and reduce once.
    function automatic gf_wide_t gf_shift_in(input gf_wide_t v, input logic b,
                                             input gf_wide_t poly_low, input gf_deg_t m);
        gf_wide_t s;
        s = {v[GF_MAXW-1:0], b};
        if (s[m]) s = s ^ poly_low;
        return s & gf_mask(m);
    endfunction

    // One subtract-and-shift step, keeping u = g1*a and v = g2*a.
    function automatic gf_euclid_t gf_euclid_step(input gf_euclid_t s);
        gf_euclid_t n;
        gf_deg_t    du;
        gf_deg_t    dv;
        du = gf_top_bit(s.u);
        dv = gf_top_bit(s.v);
        if (du >= dv) begin
            n.u  = s.u ^ (s.v << (du - dv));
            n.v  = s.v;
            n.g1 = s.g1 ^ (s.g2 << (du - dv));
            n.g2 = s.g2;
        end else begin
            n.u  = s.v ^ (s.u << (dv - du));
            n.v  = s.u;
            n.g1 = s.g2 ^ (s.g1 << (dv - du));
            n.g2 = s.g1;
        end
        return n;
    endfunction

endpackage

// File: rtl/gf_shift_engine.sv
module gf_shift_engine
    import gf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_mul,
    input  logic             load_red,
    input  gf_deg_t          m_ld,
    input  logic [W-1:0]     mcand_in,
    input  logic [W-1:0]     mplier_in,
    input  logic [2*W-1:0]   dividend_in,
    input  gf_deg_t          m_run,
    input  logic [W-1:0]     poly_run,
    output logic             fin,
    output logic [W-1:0]     acc_out
);

    localparam int CW = $clog2(2 * W + 1);

    logic            red_mode;
    logic [CW-1:0]   cnt;
    logic [W-1:0]    mcand;
    logic [W-1:0]    mplier;
    logic [W-1:0]    acc;
    logic [2*W-1:0]  dividend;
    logic            fin_q;
    gf_wide_t        poly_w;

    assign poly_w = gf_wide_t'(poly_run) & gf_mask(m_run);

    always_ff @(posedge clk) begin
        if (rst) begin
            red_mode <= 1'b0;
            cnt      <= '0;
            mcand    <= '0;
            mplier   <= '0;
            acc      <= '0;
            dividend <= '0;
            fin_q    <= 1'b0;
        end else if (load_mul) begin
            red_mode <= 1'b0;
            cnt      <= CW'(m_ld);
            mcand    <= mcand_in;
            mplier   <= mplier_in;
            acc      <= '0;
            fin_q    <= 1'b0;
        end else if (load_red) begin
            red_mode <= 1'b1;
            cnt      <= CW'(2 * W);
            dividend <= dividend_in;
            acc      <= '0;
            fin_q    <= 1'b0;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
            fin_q <= (cnt == CW'(1));
            if (red_mode) begin
                acc      <= W'(gf_shift_in(gf_wide_t'(acc), dividend[2*W-1], poly_w, m_run));
                dividend <= dividend << 1;
            end else begin
                if (mplier[0]) acc <= acc ^ mcand;
                mcand  <= W'(gf_shift_in(gf_wide_t'(mcand), 1'b0, poly_w, m_run));
                mplier <= mplier >> 1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign fin     = fin_q;
    assign acc_out = acc;

endmodule

// File: rtl/gf_euclid_engine.sv
module gf_euclid_engine
    import gf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  gf_deg_t       m_ld,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  poly_in,
    input  gf_deg_t       m_run,
    output logic          fin,
    output logic [W-1:0]  inv_out
);

    localparam int UW = W + 1;

    logic [UW-1:0] u_q;
    logic [UW-1:0] v_q;
    logic [UW-1:0] g1_q;
    logic [UW-1:0] g2_q;
    logic          running;
    logic          fin_q;
    logic [W-1:0]  res_q;
    gf_euclid_t    cur;
    gf_euclid_t    nxt;
    gf_wide_t      full_poly;

    assign full_poly = (gf_wide_t'(poly_in) & gf_mask(m_ld)) | (gf_wide_t'(1) << m_ld);

    always_comb begin
        cur.u  = gf_wide_t'(u_q);
        cur.v  = gf_wide_t'(v_q);
        cur.g1 = gf_wide_t'(g1_q);
        cur.g2 = gf_wide_t'(g2_q);
        nxt    = gf_euclid_step(cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            u_q     <= '0;
            v_q     <= '0;
            g1_q    <= '0;
            g2_q    <= '0;
            running <= 1'b0;
            fin_q   <= 1'b0;
            res_q   <= '0;
        end else if (load) begin
            u_q     <= {1'b0, a_in};
            v_q     <= UW'(full_poly);
            g1_q    <= UW'(1);
            g2_q    <= '0;
            running <= 1'b1;
            fin_q   <= 1'b0;
        end else if (running) begin
            if (u_q[UW-1:1] == '0) begin
                running <= 1'b0;
                fin_q   <= 1'b1;
                res_q   <= u_q[0] ? W'(gf_wide_t'(g1_q) & gf_mask(m_run)) : '0;
            end else begin
                u_q   <= UW'(nxt.u);
                v_q   <= UW'(nxt.v);
                g1_q  <= UW'(nxt.g1);
                g2_q  <= UW'(nxt.g2);
                fin_q <= 1'b0;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign fin     = fin_q;
    assign inv_out = res_q;

endmodule

// File: rtl/gf_arith_unit.sv
module gf_arith_unit
    import gf_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [DW-1:0]   deg,
    input  logic [2*W-1:0]  opa,
    input  logic [W-1:0]    opb,
    input  logic [W-1:0]    modpoly,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    result
);

    gf_state_e     state_q;
    gf_op_e        op_e;
    gf_deg_t       m_eff;
    gf_deg_t       m_q;
    logic [W-1:0]  poly_q;
    logic [W-1:0]  mask_w;
    logic [W-1:0]  a_lo;
    logic [W-1:0]  b_lo;
    logic [W-1:0]  poly_lo;
    logic          accept;
    logic          shift_fin;
    logic [W-1:0]  shift_res;
    logic          inv_fin;
    logic [W-1:0]  inv_res;

    assign op_e    = gf_op_e'(op);
    assign m_eff   = ((deg == '0) || (deg > DW'(W))) ? gf_deg_t'(W) : gf_deg_t'(deg);
    assign mask_w  = W'(gf_mask(m_eff));
    assign a_lo    = opa[W-1:0] & mask_w;
    assign b_lo    = opb & mask_w;
    assign poly_lo = modpoly & mask_w;
    assign accept  = start && (state_q == GF_ST_IDLE);

    gf_shift_engine #(.W(W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_mul    (accept && (op_e == GF_OP_MUL)),
        .load_red    (accept && (op_e == GF_OP_RED)),
        .m_ld        (m_eff),
        .mcand_in    (a_lo),
        .mplier_in   (b_lo),
        .dividend_in (opa),
        .m_run       (m_q),
        .poly_run    (poly_q),
        .fin         (shift_fin),
        .acc_out     (shift_res)
    );

    gf_euclid_engine #(.W(W)) u_euclid (
        .clk     (clk),
        .rst     (rst),
        .load    (accept && (op_e == GF_OP_INV)),
        .m_ld    (m_eff),
        .a_in    (a_lo),
        .poly_in (poly_lo),
        .m_run   (m_q),
        .fin     (inv_fin),
        .inv_out (inv_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GF_ST_IDLE;
            m_q     <= gf_deg_t'(W);
            poly_q  <= '0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                m_q    <= m_eff;
                poly_q <= poly_lo;
                unique case (op_e)
                    GF_OP_ADD: begin
                        result <= a_lo ^ b_lo;
                        done   <= 1'b1;
                    end
                    GF_OP_INV: state_q <= GF_ST_EUCLID;
                    default:   state_q <= GF_ST_SHIFT;
                endcase
            end else if ((state_q == GF_ST_SHIFT) && shift_fin) begin
                result  <= shift_res;
                done    <= 1'b1;
                state_q <= GF_ST_IDLE;
            end else if ((state_q == GF_ST_EUCLID) && inv_fin) begin
                result  <= inv_res;
                done    <= 1'b1;
                state_q <= GF_ST_IDLE;
            end
        end
    end

    assign busy = (state_q != GF_ST_IDLE);

endmodule

// File: rtl/gf_arith_checker.sv
module gf_arith_checker #(
    parameter int W  = 8,
    parameter int DW = $clog2(W + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [1:0]     op,
    input logic [DW-1:0]  deg,
    input logic           busy,
    input logic           done,
    input logic [W-1:0]   result
);

    localparam int BCW = $clog2(2 * W + 4) + 1;

    logic           acc_c;
    logic [BCW-1:0] busy_run;
    logic [W-1:0]   field_c;
    int             m_now;

    assign acc_c = start && !busy;
    assign m_now = ((deg == '0) || (int'(deg) > W)) ? W : int'(deg);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
            field_c  <= '1;
        end else begin
            busy_run <= busy ? busy_run + 1'b1 : '0;
            if (acc_c) begin
                for (int i = 0; i < W; i++) field_c[i] <= (i < m_now);
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy && !done && (result == '0)));                            // R1
    AST_ADD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (acc_c && (op == 2'b01)) |=> (done && !busy));                          // R3
    AST_LONG_OP_BUSY: assert property (@(posedge clk) disable iff (rst)
        (acc_c && (op != 2'b01)) |=> (busy && !done));                          // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                        // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));                                             // R9
    AST_NO_HANG: assert property (@(posedge clk) disable iff (rst)
        busy_run <= BCW'(2 * W + 1));                                           // R4
    AST_RESULT_IN_FIELD: assert property (@(posedge clk) disable iff (rst)
        done |-> ((result & ~field_c) == '0));                                  // R7

endmodule

bind gf_arith_unit gf_arith_checker #(.W(W), .DW(DW)) u_gf_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .deg    (deg),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/gf_arith_unit_bench.sv
module gf_arith_unit_bench;

    localparam int W  = 8;
    localparam int DW = $clog2(W + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [1:0]      op_i = 2'b00;
    logic [DW-1:0]   deg_i = '0;
    logic [2*W-1:0]  opa_i = '0;
    logic [W-1:0]    opb_i = '0;
    logic [W-1:0]    poly_i = '0;
    logic            busy;
    logic            done;
    logic [W-1:0]    result;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gf_arith_unit #(.W(W), .DW(DW)) u_gf_arith_unit (
        .clk(clk), .rst(rst), .start(start), .op(op_i), .deg(deg_i),
        .opa(opa_i), .opb(opb_i), .modpoly(poly_i),
        .busy(busy), .done(done), .result(result)
    );

    function automatic int eff_m(input int d);
        return (d == 0 || d > W) ? W : d;
    endfunction

    function automatic int ref_mod(input int p, input int poly, input int m);
        int full;
        int r;
        full = (poly & ((1 << m) - 1)) | (1 << m);
        r = p;
        for (int i = 30; i >= m; i--) begin
            if (((r >> i) & 1) == 1) r = r ^ (full << (i - m));
        end
        return r;
    endfunction

    function automatic int ref_mul(input int a, input int b, input int poly, input int m);
        int msk;
        int p;
        msk = (1 << m) - 1;
        p = 0;
        for (int i = 0; i < m; i++) begin
            if ((((b & msk) >> i) & 1) == 1) p = p ^ ((a & msk) << i);
        end
        return ref_mod(p, poly, m);
    endfunction

    function automatic int ref_inv(input int a, input int poly, input int m);
        for (int x = 1; x < (1 << m); x++) begin
            if (ref_mul(a, x, poly, m) == 1) return x;
        end
        return 0;
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input int d, input int a, input int b,
                         input int poly, output int res, output int lat, output bit busy0);
        @(negedge clk);
        start  = 1'b1;
        op_i   = op;
        deg_i  = DW'(d);
        opa_i  = (2*W)'(a);
        opb_i  = W'(b);
        poly_i = W'(poly);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        busy0 = busy;
        lat   = 0;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        res = int'(result);
    endtask

    task automatic run_checked(input string tag, input logic [1:0] op, input int d, input int a,
                               input int b, input int poly);
        int res;
        int lat;
        bit b0;
        int m;
        int exp_r;
        m = eff_m(d);
        do_op(op, d, a, b, poly, res, lat, b0);
        case (op)
            2'b00: begin exp_r = ref_mul(a, b, poly, m);            check({tag, " R2 lat"}, lat, m + 1); end
            2'b01: begin exp_r = (a ^ b) & ((1 << m) - 1);          check({tag, " R3 lat"}, lat, 0); end
            2'b10: begin exp_r = ref_inv(a & ((1 << m) - 1), poly, m);
                         check({tag, " R4 lat bound"}, int'(lat <= 2 * m + 2), 1); end
            default: begin exp_r = ref_mod(a & 16'hFFFF, poly, m);  check({tag, " R5 lat"}, lat, 2 * W + 1); end
        endcase
        check({tag, " R10 busy"}, int'(b0), int'(op != 2'b01));
        check({tag, " result"}, res, exp_r);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int res;
        int lat;
        bit b0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        check("R1 result in reset", int'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after reset", int'(result), 0);

        // R2 directed products
        do_op(2'b00, 3, 7, 5, 3, res, lat, b0);
        check("R2 gf8 product", res, 6);
        check("R2 gf8 latency", lat, 4);
        do_op(2'b00, 8, 8'h80, 8'h83, 8'h1B, res, lat, b0);
        check("R2 gf256 product", res, 1);
        check("R2 gf256 latency", lat, 9);

        // R3 add, upper bits dropped
        do_op(2'b01, 4, 8'hFF, 8'h0F, 0, res, lat, b0);
        check("R3 add masked", res, 0);
        check("R3 add latency", lat, 0);
        check("R3 add not busy", int'(b0), 0);

        // R4 inverse cases
        do_op(2'b10, 8, 8'h53, 0, 8'h1B, res, lat, b0);
        check("R4 inverse 0x53", res, 8'hCA);
        do_op(2'b10, 8, 0, 0, 8'h1B, res, lat, b0);
        check("R4 inverse of zero", res, 0);
        do_op(2'b10, 4, 2, 0, 8'h04, res, lat, b0);
        check("R4 reducible modulus", res, 0);

        // R5 reduce
        do_op(2'b11, 8, 16'h0100, 0, 8'h1B, res, lat, b0);
        check("R5 reduce x^8", res, 8'h1B);
        check("R5 reduce latency", lat, 17);

        // R6 out-of-range degree
        do_op(2'b00, 0, 8'h80, 8'h83, 8'h1B, res, lat, b0);
        check("R6 deg zero as W", res, 1);
        do_op(2'b00, 12, 8'h80, 8'h83, 8'h1B, res, lat, b0);
        check("R6 deg above W as W", res, 1);
        check("R6 deg above W latency", lat, 9);

        // R7 high bits ignored in operands and modulus
        do_op(2'b00, 3, 16'hFFFF, 8'hF5, 8'hFB, res, lat, b0);
        check("R7 high bits ignored", res, 6);

        // R8 start during busy ignored
        @(negedge clk);
        start = 1'b1; op_i = 2'b00; deg_i = DW'(3); opa_i = 16'h7; opb_i = 8'h5; poly_i = 8'h3;
        @(posedge clk);
        @(negedge clk);
        op_i = 2'b01; opa_i = 16'h1; opb_i = 8'h2;
        lat = 0;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check("R8 result with busy start", int'(result), 6);
        check("R8 latency with busy start", lat, 4);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 no extra done", int'(done), 0);
            check("R9 result held", int'(result), 6);
        end

        // R9 done is a single pulse
        do_op(2'b11, 5, 16'hBEEF, 0, 8'h05, res, lat, b0);
        @(negedge clk);
        check("R9 done one cycle", int'(done), 0);

        // constrained random mix
        for (int t = 0; t < 150; t++) begin
            logic [1:0] rop;
            int rd;
            rop = 2'($urandom_range(0, 3));
            rd  = int'($urandom_range(1, W));
            run_checked($sformatf("rand%0d", t), rop, rd, int'($urandom_range(0, 16'hFFFF)),
                        int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule